// File: doc/BRIEF.md
# Two-Lane Unfolded Delayed-Feedback Recursion

This block evaluates the recursion y(n) = a·y(n−9) + x(n) at a rate of two samples per clock. The single-sample loop is unfolded by a factor of two, so one clock carries a pair of consecutive samples. The even lane takes sample 2k and the odd lane takes sample 2k+1. Each lane has its own multiply-add. Neither lane feeds back to itself. The even lane's result goes to the odd lane's multiplier through a short register chain. The odd lane's result goes to the even lane's multiplier through a chain one register longer. One register in these chains spans two original sample delays.

The coefficient is a static signed fixed-point parameter with a configurable number of fractional bits. The product is shifted arithmetically right and truncated to the data width. The sum wraps modulo the data width. An input strobe marks each valid pair. On cycles without it, the whole block holds its state, so gaps in the stream do not change the results.

Top module: `unf2_recur`

## Requirements
- R1: The even output for pair k equals x(2k) + ((COEF·y(2k−9)) >>> FRAC), taken modulo 2^DW. y(2k−9) is the odd-lane result from 5 valid pairs earlier.
- R2: The odd output for pair k equals x(2k+1) + ((COEF·y(2k−8)) >>> FRAC), taken modulo 2^DW. y(2k−8) is the even-lane result from 4 valid pairs earlier.
- R3: For the first 5 valid pairs after reset, the even output equals the even input. For the first 4 valid pairs, the odd output equals the odd input. History before reset counts as zero.
- R4: While rst_n is low, and on the first edge after it is released, out_valid, y_even and y_odd are 0. Reset also clears all feedback history.
- R5: While in_valid is low, y_even and y_odd hold their values and no feedback register moves. Results after a gap match those of the same samples sent with no gap.
- R6: out_valid is high in exactly the cycle after an edge where in_valid was high. The outputs are registered, with one cycle of latency.
- R7: Arithmetic is two's complement. The product is shifted right arithmetically by FRAC and truncated to DW bits, and the sum wraps on overflow with no saturation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Marks a valid sample pair on x_even/x_odd |
| x_even | input | DW | Sample 2k, signed |
| x_odd | input | DW | Sample 2k+1, signed |
| out_valid | output | 1 | Marks a valid result pair |
| y_even | output | DW | Result y(2k), signed |
| y_odd | output | DW | Result y(2k+1), signed |

## Verification
The hardest case to reach is wraparound inside the loop. A result overflows, and the wrapped value then has to feed back through the cross-lane chains, several pairs later and on the other lane. The stimulus reaches it by sending long runs of full-scale positive inputs and then full-scale negative inputs, so the loop gain pushes results past the range. A random stream with random gaps in in_valid then checks that the lane pairing and chain depths stay aligned when valid pairs are not back to back. A reset in the middle of the run confirms that old history is gone.

// File: rtl/unf2_pkg.sv
// Shared constants for the two-lane unfolded recursion.
// Assumes an unfolding factor of two and a recursion distance of nine samples.
package unf2_pkg;
    localparam int UNFOLD     = 2;
    localparam int RECUR_DIST = 9;

    // Number of feedback registers on the path leaving a given source lane.
    function automatic int fb_depth(input int src_lane);
        return (src_lane + RECUR_DIST) / UNFOLD;
    endfunction

    // Lane that consumes the result of a given source lane.
    function automatic int fb_target(input int src_lane);
        return (src_lane + RECUR_DIST) % UNFOLD;
    endfunction
endpackage

// File: rtl/unf2_mac.sv
// One lane's multiply-add: y = x + trunc((COEF * yd) >>> FRAC).
// Combinational only. Assumes FRAC < DW + CW. The result wraps modulo 2^DW.
module unf2_mac #(
    parameter int DW   = 16,
    parameter int CW   = 8,
    parameter int FRAC = 6,
    parameter int COEF = 48
) (
    input  logic signed [DW-1:0] x_i,
    input  logic signed [DW-1:0] yd_i,
    output logic signed [DW-1:0] y_o
);
    localparam int PW = DW + CW;
    localparam logic signed [CW-1:0] COEF_V = CW'(COEF);

    logic signed [PW-1:0] prod;
    logic signed [PW-1:0] prod_sh;

    // Full-width product, then scale down by the coefficient's fraction bits.
    always_comb begin
        prod    = PW'(yd_i) * PW'(COEF_V);
        prod_sh = prod >>> FRAC;
        y_o     = x_i + prod_sh[DW-1:0];
    end
endmodule

// File: rtl/unf2_fb_line.sv
// Feedback register chain of DEPTH stages that shifts only when adv_i is high.
// Assumes DEPTH >= 1. Every stage clears on a synchronous active-low reset.
module unf2_fb_line #(
    parameter int DW    = 16,
    parameter int DEPTH = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          adv_i,
    input  logic [DW-1:0] d_i,
    output logic [DW-1:0] q_o
);
    logic [DW-1:0] stage [DEPTH];

    // First stage captures the incoming lane result.
    always_ff @(posedge clk) begin
        if (!rst_n)     stage[0] <= '0;
        else if (adv_i) stage[0] <= d_i;
    end

    // Remaining stages each take the value of the stage before them.
    for (genvar g = 1; g < DEPTH; g++) begin : g_stage
        always_ff @(posedge clk) begin
            if (!rst_n)     stage[g] <= '0;
            else if (adv_i) stage[g] <= stage[g-1];
        end
    end

    assign q_o = stage[DEPTH-1];
endmodule

// File: rtl/unf2_recur.sv
// Top of the two-lane unfolded recursion y(n) = COEF*y(n-9) + x(n).
// Even lane handles sample 2k, odd lane handles 2k+1. Each lane feeds the other
// through a chain whose depth comes from the unfolding rule. Assumes a
// synchronous active-low reset. When in_valid is low, all state holds.
module unf2_recur #(
    parameter int DW   = 16,
    parameter int CW   = 8,
    parameter int FRAC = 6,
    parameter int COEF = 48
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic signed [DW-1:0] x_even,
    input  logic signed [DW-1:0] x_odd,
    output logic                 out_valid,
    output logic signed [DW-1:0] y_even,
    output logic signed [DW-1:0] y_odd
);
    localparam int N_LANE = unf2_pkg::UNFOLD;

    logic signed [DW-1:0] x_lane  [N_LANE];
    logic signed [DW-1:0] y_lane  [N_LANE];
    logic signed [DW-1:0] yd_lane [N_LANE];

    assign x_lane[0] = x_even;
    assign x_lane[1] = x_odd;

    for (genvar l = 0; l < N_LANE; l++) begin : g_lane
        localparam int DST   = unf2_pkg::fb_target(l);
        localparam int DEPTH = unf2_pkg::fb_depth(l);
        logic [DW-1:0] fb_q;

        unf2_mac #(.DW(DW), .CW(CW), .FRAC(FRAC), .COEF(COEF)) u_mac (
            .x_i  (x_lane[l]),
            .yd_i (yd_lane[l]),
            .y_o  (y_lane[l])
        );

        unf2_fb_line #(.DW(DW), .DEPTH(DEPTH)) u_fb (
            .clk   (clk),
            .rst_n (rst_n),
            .adv_i (in_valid),
            .d_i   (y_lane[l]),
            .q_o   (fb_q)
        );

        // Route this lane's delayed result to the multiplier of the other lane.
        assign yd_lane[DST] = fb_q;
    end

    // Output register holding the latest result pair and its valid flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            y_even    <= '0;
            y_odd     <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                y_even <= y_lane[0];
                y_odd  <= y_lane[1];
            end
        end
    end
endmodule

// File: rtl/unf2_recur_chk.sv
// Checker for unf2_recur, bound to every instance below.
// Keeps its own count of valid pairs since reset to check the zero-history window.
module unf2_recur_chk #(
    parameter int DW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          in_valid,
    input logic [DW-1:0] x_even,
    input logic [DW-1:0] x_odd,
    input logic          out_valid,
    input logic [DW-1:0] y_even,
    input logic [DW-1:0] y_odd
);
    localparam int EVEN_WIN = unf2_pkg::fb_depth(1);
    localparam int ODD_WIN  = unf2_pkg::fb_depth(0);

    logic [3:0] pairs;

    // Saturating count of valid pairs accepted since reset.
    always_ff @(posedge clk) begin
        if (!rst_n)                       pairs <= '0;
        else if (in_valid && pairs != 4'hF) pairs <= pairs + 4'd1;
    end

    // R6
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    // R6
    valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    // R5
    hold_on_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(y_even) && $stable(y_odd)));
    // R4
    reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!out_valid && y_even == '0 && y_odd == '0));
    // R3
    even_no_history_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && pairs < 4'(EVEN_WIN)) |=> (y_even == $past(x_even)));
    // R3
    odd_no_history_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && pairs < 4'(ODD_WIN)) |=> (y_odd == $past(x_odd)));
endmodule

bind unf2_recur unf2_recur_chk #(.DW(DW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .x_even    (x_even),
    .x_odd     (x_odd),
    .out_valid (out_valid),
    .y_even    (y_even),
    .y_odd     (y_odd)
);

// File: tb/tb_unf2_recur.sv
// Bench for unf2_recur. A one-sample-at-a-time reference model computes every
// expected result in order and is compared against both lanes.
module tb_unf2_recur;
    localparam int DW    = 16;
    localparam int CW    = 8;
    localparam int FRAC  = 6;
    localparam int COEF  = 48;
    localparam int HMAX  = 4096;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 in_valid = 1'b0;
    logic signed [DW-1:0] x_even = '0;
    logic signed [DW-1:0] x_odd = '0;
    logic                 out_valid;
    logic signed [DW-1:0] y_even;
    logic signed [DW-1:0] y_odd;

    int checks = 0;
    int errors = 0;
    int n_idx  = 0;
    logic signed [DW-1:0] hist [HMAX];
    logic signed [DW-1:0] last_e = '0;
    logic signed [DW-1:0] last_o = '0;

    unf2_recur #(.DW(DW), .CW(CW), .FRAC(FRAC), .COEF(COEF)) dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .x_even(x_even), .x_odd(x_odd),
        .out_valid(out_valid), .y_even(y_even), .y_odd(y_odd)
    );

    always #5 clk = ~clk;

    // Reference for one sample: x + ((COEF*y(n-9)) >>> FRAC), wrapped (R7).
    function automatic logic signed [DW-1:0] ref_step(input logic signed [DW-1:0] x,
                                                      input int n);
        longint yd;
        longint p;
        longint s;
        yd = (n >= 9) ? longint'(hist[n-9]) : 64'sd0;
        p  = (yd * longint'(COEF)) >>> FRAC;
        s  = longint'(x) + p;
        return s[DW-1:0];
    endfunction

    task automatic check(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Drive one cycle, then compare the results at the next falling edge.
    task automatic step(input logic v, input logic signed [DW-1:0] xe,
                        input logic signed [DW-1:0] xo);
        logic signed [DW-1:0] ee;
        logic signed [DW-1:0] eo;
        in_valid = v;
        x_even   = xe;
        x_odd    = xo;
        ee = last_e;
        eo = last_o;
        if (v) begin
            ee = ref_step(xe, n_idx);
            hist[n_idx] = ee;
            eo = ref_step(xo, n_idx + 1);
            hist[n_idx+1] = eo;
            n_idx += 2;
        end
        @(negedge clk);
        if (v) begin
            check("R6 out_valid", longint'(out_valid), 1);
            check("R1 even lane", longint'(y_even), longint'(ee));
            check("R2 odd lane", longint'(y_odd), longint'(eo));
        end else begin
            check("R6 out_valid idle", longint'(out_valid), 0);
            check("R5 even hold", longint'(y_even), longint'(ee));
            check("R5 odd hold", longint'(y_odd), longint'(eo));
        end
        last_e = ee;
        last_o = eo;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        in_valid = 1'b0;
        repeat (2) @(negedge clk);
        check("R4 reset out_valid", longint'(out_valid), 0);
        check("R4 reset y_even", longint'(y_even), 0);
        check("R4 reset y_odd", longint'(y_odd), 0);
        rst_n = 1'b1;
        n_idx = 0;
        last_e = '0;
        last_o = '0;
    endtask

    initial begin
        void'($urandom(32'd1234));
        @(negedge clk);
        do_reset();
        // R3: the first pairs see zero history, so the outputs equal the inputs.
        for (int i = 0; i < 6; i++) begin
            step(1'b1, DW'(100 + i), DW'(-200 - i));
            if (i < 5) check("R3 even no history", longint'(y_even), longint'(DW'(100 + i)));
            if (i < 4) check("R3 odd no history", longint'(y_odd), longint'(DW'(-200 - i)));
        end
        // R7: full-scale runs drive the loop into wraparound.
        for (int i = 0; i < 30; i++) step(1'b1, 16'sh7FFF, 16'sh7FFF);
        for (int i = 0; i < 30; i++) step(1'b1, 16'sh8000, 16'sh8000);
        // R5: a gap in the middle of the stream.
        for (int i = 0; i < 4; i++) step(1'b0, 16'sh1234, 16'sh4321);
        // Random stream with random gaps.
        for (int i = 0; i < 800; i++) begin
            step(($urandom % 4) != 0, DW'($urandom), DW'($urandom));
        end
        // R4: reset in the middle of the run clears the history.
        do_reset();
        for (int i = 0; i < 6; i++) begin
            step(1'b1, DW'(7 * i + 1), DW'(-3 * i - 1));
            if (i < 4) check("R4 history cleared", longint'(y_odd), longint'(DW'(-3 * i - 1)));
        end
        for (int i = 0; i < 200; i++) begin
            step(($urandom % 3) != 0, DW'($urandom), DW'($urandom));
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #1000000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule